// File: doc/BRIEF.md
# Multiplier-Free Adaptive LMS FIR Filter

This block is a small adaptive FIR filter. Its tap weights follow the least-mean-squares rule, and it has no hardware multiplier. Every product comes from a lookup table combined with shifting and adding. Two tables of 2^TAPS entries share one addressing scheme, in which bit k of an address selects tap k.

- The weight table holds every subset sum of the tap weights.
- The sample table holds every subset sum of the most recent input samples.

A base filter unit forms the output. It walks the stored samples one bit position per cycle, uses the bit-slice across all taps as the weight-table address, and accumulates the entries it reads with their binary weight. An adaptation unit then takes the error between the desired response and the output. It multiplies the error by every sample-table entry at once, by shift-and-add over the error bits, and adds the scaled result to the matching weight-table entry.

The user pulses a strobe with a new sample and its desired response. A fixed number of cycles later, the output and the error appear, flagged by a one-cycle valid pulse. That number depends on the sample and error widths only, never on the tap count.

Top module: `dalms_lms_filter`

## Requirements
- R1: During reset and after it, `busy_o`, `out_valid_o`, `y_o` and `err_o` are zero and every weight-table entry is zero, so the first output after reset is 0 and its error equals the desired value.
- R2: A strobe accepted while idle shifts the delay line: tap 0 takes the new sample and tap k takes the old tap k-1. Sample-table entry a then becomes the sum of the taps k whose bit k is set in a, and entry 0 is 0.
- R3: The output is computed LSB first. For bit positions b = 0 to XW-1, the address is the bit b of every tap (tap k on address bit k). The entry read is added, shifted left by b, except at b = XW-1, where it is subtracted. The accumulated value is shifted right arithmetically by FW and clamped to the signed YW-bit range to give `y_o`.
- R4: `err_o` equals the captured desired value minus `y_o`, clamped to the signed EW-bit range.
- R5: After each output, every weight-table entry a ≥ 1 becomes F[a] + ((e·A[a] + 2^(MU_SH-1)) >>> MU_SH), clamped to the signed TW-bit range. Entry 0 stays zero, and the table does not change at any other time.
- R6: `out_valid_o` rises exactly XW+EW+3 clock edges after the edge that accepts the strobe, for one cycle, and is low at all cycles in between.
- R7: `busy_o` is high from the edge after acceptance until the valid edge. Strobes that arrive while busy are ignored and do not change the delay line or later outputs.
- R8: When the filter identifies a fixed 4-tap system driven by samples in ±100, the error magnitude in the last 50 of 400 samples stays at or below 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sample_stb_i | input | 1 | Presents a new sample and desired value |
| sample_i | input | XW | Input sample, two's complement |
| desired_i | input | XW | Desired response, two's complement |
| busy_o | output | 1 | Computation in progress |
| out_valid_o | output | 1 | One-cycle pulse when y_o and err_o are new |
| y_o | output | YW | Filter output, two's complement |
| err_o | output | EW | Error, desired minus output |

## Verification
The bench compares each output with an independent table-level model over several input patterns, each of which separates a different fault:
- An impulse followed by zeros isolates the ordering of the delay line.
- Full-scale positive and negative samples exercise the subtracted MSB slice.
- Uncorrelated random samples and desired values exercise every table address together with the weight update.
- A strobe injected mid-computation tells an ignored strobe apart from a spurious shift.
- A system-identification run confirms that the error actually collapses.

// File: rtl/dalms_pkg.sv
`timescale 1ns/1ps
package dalms_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_FILT,
        ST_ERR,
        ST_UPD,
        ST_APPLY
    } dalms_state_e;

endpackage

// File: rtl/dalms_sample_table.sv
`timescale 1ns/1ps
module dalms_sample_table #(
    parameter int TAPS = 4,
    parameter int XW   = 8,
    parameter int SW   = 10
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          shift_i,
    input  logic                          load_i,
    input  logic [XW-1:0]                 sample_i,
    output logic [TAPS-1:0][XW-1:0]       taps_o,
    output logic [(1<<TAPS)-1:0][SW-1:0]  sums_o
);
    localparam int NE = 1 << TAPS;

    typedef struct packed {
        logic [TAPS-1:0][XW-1:0] taps;
        logic [NE-1:0][SW-1:0]   sums;
    } tbl_t;

    tbl_t st_d, st_q;
    logic [SW-1:0] part;

    always_comb begin
        st_d = st_q;
        part = '0;
        if (shift_i) begin
            for (int k = TAPS - 1; k > 0; k--) begin
                st_d.taps[k] = st_q.taps[k-1];
            end
            st_d.taps[0] = sample_i;
        end
        if (load_i) begin
            for (int a = 0; a < NE; a++) begin
                part = '0;
                for (int k = 0; k < TAPS; k++) begin
                    if (((a >> k) & 1) != 0) begin
                        part = part + SW'($signed(st_q.taps[k]));
                    end
                end
                st_d.sums[a] = part;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign taps_o = st_q.taps;
    assign sums_o = st_q.sums;

    AST_TAPS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_i |=> $stable(st_q.taps)); // R2
    AST_SUMS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(st_q.sums)); // R2

endmodule

// File: rtl/dalms_base_filter.sv
`timescale 1ns/1ps
module dalms_base_filter #(
    parameter int TAPS = 4,
    parameter int XW   = 8,
    parameter int TW   = 18,
    parameter int AW   = 27,
    parameter int BW   = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clear_i,
    input  logic                    step_i,
    input  logic                    msb_i,
    input  logic [BW-1:0]           bit_i,
    input  logic [TAPS-1:0][XW-1:0] taps_i,
    input  logic [TW-1:0]           entry_i,
    output logic [TAPS-1:0]         addr_o,
    output logic [AW-1:0]           acc_o
);
    typedef struct packed {
        logic signed [AW-1:0] acc;
    } flt_t;

    flt_t st_d, st_q;
    logic signed [AW-1:0] term;

    always_comb begin
        for (int k = 0; k < TAPS; k++) begin
            addr_o[k] = taps_i[k][bit_i];
        end
    end

    always_comb begin
        st_d = st_q;
        term = AW'($signed(entry_i));
        term = term <<< bit_i;
        if (clear_i) begin
            st_d.acc = '0;
        end else if (step_i) begin
            if (msb_i) st_d.acc = st_q.acc - term;
            else       st_d.acc = st_q.acc + term;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign acc_o = st_q.acc;

    AST_ACC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (acc_o == '0)); // R3
    AST_ACC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_i && !step_i) |=> $stable(acc_o)); // R3

endmodule

// File: rtl/dalms_adapt_unit.sv
`timescale 1ns/1ps
module dalms_adapt_unit #(
    parameter int TAPS  = 4,
    parameter int SW    = 10,
    parameter int EW    = 11,
    parameter int TW    = 18,
    parameter int PW    = 21,
    parameter int MU_SH = 4,
    parameter int BW    = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          clear_i,
    input  logic                          step_i,
    input  logic                          msb_i,
    input  logic [BW-1:0]                 bit_i,
    input  logic [EW-1:0]                 err_i,
    input  logic [(1<<TAPS)-1:0][SW-1:0]  sums_i,
    input  logic                          apply_i,
    input  logic [TAPS-1:0]               addr_i,
    output logic [TW-1:0]                 entry_o
);
    localparam int NE   = 1 << TAPS;
    localparam int SUMW = ((PW > TW) ? PW : TW) + 1;
    localparam logic signed [PW-1:0]   RND   = (MU_SH > 0) ? PW'(1 << (MU_SH - 1)) : '0;
    localparam logic signed [SUMW-1:0] T_MAX = {{(SUMW-TW+1){1'b0}}, {(TW-1){1'b1}}};
    localparam logic signed [SUMW-1:0] T_MIN = {{(SUMW-TW+1){1'b1}}, {(TW-1){1'b0}}};

    typedef struct packed {
        logic [NE-1:0][TW-1:0] f;
        logic [NE-1:0][PW-1:0] prod;
    } ada_t;

    ada_t st_d, st_q;
    logic signed [PW-1:0]   term;
    logic signed [PW-1:0]   delta;
    logic signed [SUMW-1:0] sumv;

    always_comb begin
        st_d  = st_q;
        term  = '0;
        delta = '0;
        sumv  = '0;
        if (clear_i) begin
            st_d.prod = '0;
        end else if (step_i && err_i[bit_i]) begin
            for (int a = 0; a < NE; a++) begin
                term = PW'($signed(sums_i[a]));
                term = term <<< bit_i;
                if (msb_i) st_d.prod[a] = st_q.prod[a] - term;
                else       st_d.prod[a] = st_q.prod[a] + term;
            end
        end
        if (apply_i) begin
            for (int a = 1; a < NE; a++) begin
                delta = ($signed(st_q.prod[a]) + RND) >>> MU_SH;
                sumv  = SUMW'($signed(st_q.f[a])) + SUMW'(delta);
                if (sumv > T_MAX)      st_d.f[a] = T_MAX[TW-1:0];
                else if (sumv < T_MIN) st_d.f[a] = T_MIN[TW-1:0];
                else                   st_d.f[a] = sumv[TW-1:0];
            end
            st_d.f[0] = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign entry_o = st_q.f[addr_i];

    AST_TABLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !apply_i |=> $stable(st_q.f)); // R5
    AST_PROD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (st_q.prod == '0)); // R5

endmodule

// File: rtl/dalms_lms_filter.sv
`timescale 1ns/1ps
module dalms_lms_filter #(
    parameter int TAPS  = 4,
    parameter int XW    = 8,
    parameter int FW    = 12,
    parameter int TW    = 18,
    parameter int YW    = 10,
    parameter int EW    = 11,
    parameter int MU_SH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sample_stb_i,
    input  logic [XW-1:0] sample_i,
    input  logic [XW-1:0] desired_i,
    output logic          busy_o,
    output logic          out_valid_o,
    output logic [YW-1:0] y_o,
    output logic [EW-1:0] err_o
);
    import dalms_pkg::*;

    localparam int NE     = 1 << TAPS;
    localparam int SW     = XW + $clog2(TAPS);
    localparam int AW     = TW + XW + 1;
    localparam int PW     = SW + EW;
    localparam int CNTMAX = (EW > XW) ? EW : XW;
    localparam int BW     = $clog2(CNTMAX);
    localparam int MW     = (YW > EW) ? ((YW > XW) ? YW : XW) : ((EW > XW) ? EW : XW);
    localparam int GW     = MW + 2;
    localparam logic signed [AW-1:0] Y_MAX = {{(AW-YW+1){1'b0}}, {(YW-1){1'b1}}};
    localparam logic signed [AW-1:0] Y_MIN = {{(AW-YW+1){1'b1}}, {(YW-1){1'b0}}};
    localparam logic signed [GW-1:0] E_MAX = {{(GW-EW+1){1'b0}}, {(EW-1){1'b1}}};
    localparam logic signed [GW-1:0] E_MIN = {{(GW-EW+1){1'b1}}, {(EW-1){1'b0}}};

    typedef struct packed {
        dalms_state_e   state;
        logic [BW-1:0]  cnt;
        logic [XW-1:0]  d;
        logic [YW-1:0]  y;
        logic [EW-1:0]  e;
        logic           valid;
    } ctl_t;

    ctl_t st_d, st_q;

    logic                          shift_w, load_w, fstep_w, fmsb_w, astep_w, amsb_w, apply_w;
    logic [TAPS-1:0][XW-1:0]       taps_w;
    logic [NE-1:0][SW-1:0]         sums_w;
    logic [TAPS-1:0]               addr_w;
    logic [TW-1:0]                 entry_w;
    logic [AW-1:0]                 acc_w;
    logic signed [AW-1:0]          ysh;
    logic signed [YW-1:0]          ynew;
    logic signed [GW-1:0]          diff;
    logic signed [EW-1:0]          enew;

    // Control strobes decoded from the sequencer state
    always_comb begin
        shift_w = (st_q.state == ST_IDLE) && sample_stb_i;
        load_w  = (st_q.state == ST_LOAD);
        fstep_w = (st_q.state == ST_FILT);
        fmsb_w  = (st_q.cnt == BW'(XW - 1));
        astep_w = (st_q.state == ST_UPD);
        amsb_w  = (st_q.cnt == BW'(EW - 1));
        apply_w = (st_q.state == ST_APPLY);
    end

    // Output scaling and error forming
    always_comb begin
        ysh = $signed(acc_w) >>> FW;
        if (ysh > Y_MAX)      ynew = Y_MAX[YW-1:0];
        else if (ysh < Y_MIN) ynew = Y_MIN[YW-1:0];
        else                  ynew = ysh[YW-1:0];
        diff = GW'($signed(st_q.d)) - GW'(ynew);
        if (diff > E_MAX)      enew = E_MAX[EW-1:0];
        else if (diff < E_MIN) enew = E_MIN[EW-1:0];
        else                   enew = diff[EW-1:0];
    end

    // Sequencer next state
    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        case (st_q.state)
            ST_IDLE: begin
                if (sample_stb_i) begin
                    st_d.d     = desired_i;
                    st_d.state = ST_LOAD;
                end
            end
            ST_LOAD: begin
                st_d.cnt   = '0;
                st_d.state = ST_FILT;
            end
            ST_FILT: begin
                if (fmsb_w) begin
                    st_d.cnt   = '0;
                    st_d.state = ST_ERR;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
            ST_ERR: begin
                st_d.y     = ynew;
                st_d.e     = enew;
                st_d.cnt   = '0;
                st_d.state = ST_UPD;
            end
            ST_UPD: begin
                if (amsb_w) begin
                    st_d.cnt   = '0;
                    st_d.state = ST_APPLY;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
            ST_APPLY: begin
                st_d.valid = 1'b1;
                st_d.state = ST_IDLE;
            end
            default: st_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    dalms_sample_table #(
        .TAPS(TAPS), .XW(XW), .SW(SW)
    ) u_samples (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_i  (shift_w),
        .load_i   (load_w),
        .sample_i (sample_i),
        .taps_o   (taps_w),
        .sums_o   (sums_w)
    );

    dalms_base_filter #(
        .TAPS(TAPS), .XW(XW), .TW(TW), .AW(AW), .BW(BW)
    ) u_base (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (load_w),
        .step_i  (fstep_w),
        .msb_i   (fmsb_w),
        .bit_i   (st_q.cnt),
        .taps_i  (taps_w),
        .entry_i (entry_w),
        .addr_o  (addr_w),
        .acc_o   (acc_w)
    );

    dalms_adapt_unit #(
        .TAPS(TAPS), .SW(SW), .EW(EW), .TW(TW), .PW(PW), .MU_SH(MU_SH), .BW(BW)
    ) u_adapt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (load_w),
        .step_i  (astep_w),
        .msb_i   (amsb_w),
        .bit_i   (st_q.cnt),
        .err_i   (st_q.e),
        .sums_i  (sums_w),
        .apply_i (apply_w),
        .addr_i  (addr_w),
        .entry_o (entry_w)
    );

    assign busy_o      = (st_q.state != ST_IDLE);
    assign out_valid_o = st_q.valid;
    assign y_o         = st_q.y;
    assign err_o       = st_q.e;

    AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o |=> !out_valid_o); // R6
    AST_VALID_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o |-> !busy_o); // R7
    AST_START_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(sample_stb_i)); // R7

endmodule

// File: tb/dalms_lms_filter_tb.sv
`timescale 1ns/1ps
module dalms_lms_filter_tb_top;
    localparam int TAPS  = 4;
    localparam int XW    = 8;
    localparam int FW    = 12;
    localparam int TW    = 18;
    localparam int YW    = 10;
    localparam int EW    = 11;
    localparam int MU_SH = 4;
    localparam int NE    = 1 << TAPS;
    localparam int LAT   = XW + EW + 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          stb = 1'b0;
    logic [XW-1:0] x = '0;
    logic [XW-1:0] d = '0;
    logic          busy, valid;
    logic [YW-1:0] y;
    logic [EW-1:0] e;

    dalms_lms_filter #(
        .TAPS(TAPS), .XW(XW), .FW(FW), .TW(TW), .YW(YW), .EW(EW), .MU_SH(MU_SH)
    ) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .sample_stb_i (stb),
        .sample_i     (x),
        .desired_i    (d),
        .busy_o       (busy),
        .out_valid_o  (valid),
        .y_o          (y),
        .err_o        (e)
    );

    always #2.5 clk = ~clk;

    int     checks = 0;
    int     fails  = 0;
    bit     done   = 1'b0;
    longint mf[NE];
    longint ma[NE];
    longint mt[TAPS];
    longint exp_y, exp_e, last_e;

    function automatic longint clampw(longint v, int w);
        longint hi = (longint'(1) <<< (w - 1)) - 1;
        longint lo = -hi - 1;
        if (v > hi) return hi;
        if (v < lo) return lo;
        return v;
    endfunction

    task automatic check(string req, longint act, longint expv);
        checks++;
        if (act != expv) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic model_reset();
        for (int a = 0; a < NE; a++) begin mf[a] = 0; ma[a] = 0; end
        for (int k = 0; k < TAPS; k++) mt[k] = 0;
    endtask

    task automatic model_step(longint xs, longint ds);
        longint yf = 0;
        for (int k = TAPS - 1; k > 0; k--) mt[k] = mt[k-1];
        mt[0] = xs;
        for (int a = 0; a < NE; a++) begin
            longint s = 0;
            for (int k = 0; k < TAPS; k++) if (((a >> k) & 1) != 0) s += mt[k];
            ma[a] = s;
        end
        for (int b = 0; b < XW; b++) begin
            int ad = 0;
            for (int k = 0; k < TAPS; k++) ad |= int'((mt[k] >>> b) & 1) << k;
            if (b == XW - 1) yf -= mf[ad] <<< b;
            else             yf += mf[ad] <<< b;
        end
        exp_y = clampw(yf >>> FW, YW);
        exp_e = clampw(ds - exp_y, EW);
        for (int a = 1; a < NE; a++) begin
            longint p = exp_e * ma[a];
            mf[a] = clampw(mf[a] + ((p + (longint'(1) <<< (MU_SH - 1))) >>> MU_SH), TW);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 busy in reset", longint'(busy), 0);
        check("R1 valid in reset", longint'(valid), 0);
        check("R1 y in reset", longint'($signed(y)), 0);
        check("R1 err in reset", longint'($signed(e)), 0);
        rst_n = 1'b1;
        model_reset();
    endtask

    task automatic run_sample(int xs, int ds, string ytag, bit timing, bit poke);
        @(negedge clk);
        stb = 1'b1;
        x   = xs[XW-1:0];
        d   = ds[XW-1:0];
        model_step(longint'(xs), longint'(ds));
        @(negedge clk);
        stb = 1'b0;
        for (int i = 1; i < LAT; i++) begin
            @(negedge clk);
            if (poke && i == 6) begin
                stb = 1'b1;
                x   = 8'h55;
                d   = 8'h11;
            end else begin
                stb = 1'b0;
            end
        end
        if (timing) begin
            check("R6 valid low before latency", longint'(valid), 0);
            check("R7 busy during computation", longint'(busy), 1);
        end
        @(negedge clk);
        if (timing) begin
            check("R6 valid at latency", longint'(valid), 1);
            check("R7 idle at valid", longint'(busy), 0);
        end
        last_e = longint'($signed(e));
        check(ytag, longint'($signed(y)), exp_y);
        check("R4 error", last_e, exp_e);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            fails++;
            $display("FAIL watchdog R6 actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        longint ht[TAPS];
        longint maxe;
        void'($urandom(32'd20240611));
        model_reset();
        do_reset();

        // Directed: first output after reset, impulse, full-scale slices
        run_sample(100, 50, "R1 first output zero", 1'b1, 1'b0);
        run_sample(0, -20, "R2 impulse moves to tap 1", 1'b1, 1'b0);
        run_sample(0, 10, "R2 impulse moves to tap 2", 1'b0, 1'b0);
        run_sample(0, -5, "R2 impulse moves to tap 3", 1'b0, 1'b0);
        run_sample(-128, 127, "R3 negative full scale", 1'b1, 1'b0);
        run_sample(127, -128, "R3 positive full scale", 1'b0, 1'b0);
        run_sample(-1, 0, "R5 updated table read", 1'b0, 1'b0);
        // Strobe injected while busy must be ignored
        run_sample(30, 40, "R7 output with busy strobe", 1'b1, 1'b1);
        run_sample(-60, 5, "R7 ignored strobe left taps", 1'b1, 1'b0);

        // Random uncorrelated stimulus
        for (int n = 0; n < 40; n++) begin
            int xs = int'($urandom_range(255)) - 128;
            int ds = int'($urandom_range(255)) - 128;
            run_sample(xs, ds, "R3/R5 random", 1'b0, 1'b0);
        end

        // Reset clears the weight table
        do_reset();
        run_sample(77, -33, "R1 output zero after reset", 1'b1, 1'b0);
        do_reset();

        // System identification
        for (int k = 0; k < TAPS; k++) ht[k] = 0;
        maxe = 0;
        for (int n = 0; n < 400; n++) begin
            int xs = int'($urandom_range(200)) - 100;
            longint dv;
            for (int k = TAPS - 1; k > 0; k--) ht[k] = ht[k-1];
            ht[0] = xs;
            dv = (2048 * ht[0] - 1024 * ht[1] + 512 * ht[2] + 1536 * ht[3]) >>> 12;
            run_sample(xs, int'(dv), "R3/R5 identification", 1'b0, 1'b0);
            if (n >= 350) begin
                longint ae = (last_e < 0) ? -last_e : last_e;
                if (ae > maxe) maxe = ae;
            end
        end
        check("R8 converged error bound", (maxe <= 10) ? 1 : 0, 1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule